// File: doc/BRIEF.md
# Inhibitable Position Output Latch

This block sits between a free-running up/down position counter and a byte-wide host bus. Each time the counter moves by one LSB, the block starts a busy pulse of fixed width and copies the counter word into an output latch. The copy does not happen while the host holds the active-low inhibit input low. The counter itself keeps running, and busy pulses still mark every step during that time.

The inhibit input is asynchronous to the block clock, so it passes through a synchroniser before use. After the synchronised inhibit falls, a valid flag rises once a fixed delay has passed. A busy pulse that was already running therefore ends before the host reads the word. When inhibit is released, one refresh busy pulse starts and the latch reloads from the counter. The latched word is trimmed to the selected resolution of 10, 12, 14 or 16 bits. It goes out on two byte lanes, under the control of a byte-select input and an active-low output enable. The high-impedance state of the lanes is modelled as a separate lane-enable output.

Top module: `pos_latch_if`

## Requirements
- R1: After reset, busy_o and valid_o are 0 and the latch holds 0.
- R2: A step_i sampled high at a clock edge while the synchronised inhibit is inactive loads the masked pos_i into the latch at that edge. busy_o is then high for exactly BUSY_CYC cycles, starting in the next cycle.
- R3: While the synchronised inhibit is active, steps do not change the latch, but each step still starts a busy pulse.
- R4: When inhibit_ni is driven low ahead of clock edge 1, valid_o is 0 through edge VALID_CYC+2 and 1 from edge VALID_CYC+3. It stays 1 while inhibit stays low. valid_o is 0 whenever the synchronised inhibit is inactive.
- R5: When inhibit_ni is driven high ahead of edge 1, the latch reloads from pos_i at edge 3 and busy_o is high after that edge, with no step needed.
- R6: With oe_ni high, lane_oe_o is 0 and both lanes read 0. With oe_ni low, lane_oe_o is 1. Toggling oe_ni changes neither the latch nor busy_o.
- R7: When enabled, lane_b_o always carries latch bits 7:0, whatever the value of byte_hi_i.
- R8: When enabled, lane_a_o carries latch bits 15:8 if byte_hi_i is 1 and latch bits 7:0 if byte_hi_i is 0.
- R9: res_sel_i picks the resolution: 00 is 10 bits, 01 is 12 bits, 10 is 14 bits and 11 is 16 bits. pos_i is MSB-aligned. On load, the 16 minus resolution low bits are forced to 0.
- R10: A step that arrives while busy_o is high restarts the pulse, so busy_o stays high for BUSY_CYC cycles after the later step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_i | input | 16 | Counter word, MSB-aligned |
| step_i | input | 1 | Counter moved one LSB this cycle |
| inhibit_ni | input | 1 | Asynchronous latch freeze, active low |
| res_sel_i | input | 2 | Resolution select |
| oe_ni | input | 1 | Lane output enable, active low |
| byte_hi_i | input | 1 | Lane A byte select |
| lane_a_o | output | 8 | Byte lane A |
| lane_b_o | output | 8 | Byte lane B, low byte |
| lane_oe_o | output | 1 | Lane drive enable, 0 means high impedance |
| busy_o | output | 1 | Latch may be changing |
| valid_o | output | 1 | Latched word stable for reading |

## Verification
The assertions cover the following on every cycle:
- steering of bytes onto the two lanes;
- zero lanes while the output is disabled;
- no latch change while inhibit is active or valid_o is high;
- a busy pulse after every step and after every inhibit release;
- the resolution zeroing of each loaded word.

The exact busy width, the retrigger behaviour and the valid delay counted from the inhibit pin can only be shown by the bench's timed scenarios. The same holds for the fact that the enable input leaves latching untouched.

// File: rtl/pl_pkg.sv
package pl_pkg;
  localparam int POS_W  = 16;
  localparam int BYTE_W = POS_W / 2;

  typedef enum logic [1:0] {
    RES_10 = 2'b00,
    RES_12 = 2'b01,
    RES_14 = 2'b10,
    RES_16 = 2'b11
  } res_e;

  // keep the top (10 + 2*sel) bits, clear the rest
  function automatic logic [POS_W-1:0] res_mask(logic [1:0] sel);
    int unsigned drop;
    drop = POS_W - (10 + 2 * int'(sel));
    return {POS_W{1'b1}} << drop;
  endfunction
endpackage

// File: rtl/pl_sync.sv
module pl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pl_pulse.sv
module pl_pulse #(
  parameter int WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIDTH);

  logic [CW-1:0] cnt_q;

  // retriggerable: a new start reloads the full width
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pl_valid_tmr.sv
module pl_valid_tmr #(
  parameter int DELAY = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inh_act_i,
  input  logic fall_i,
  output logic valid_o
);
  localparam int TW = $clog2(DELAY + 1);
  localparam logic [TW-1:0] LOAD = TW'(DELAY);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            tmr_q <= '0;
    else if (fall_i)        tmr_q <= LOAD;
    else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;

  assign valid_o = inh_act_i && !fall_i && (tmr_q == '0);
endmodule

// File: rtl/pl_steer.sv
module pl_steer
  import pl_pkg::*;
(
  input  logic [POS_W-1:0]  word_i,
  input  logic              byte_hi_i,
  input  logic              oe_ni,
  output logic [BYTE_W-1:0] lane_a_o,
  output logic [BYTE_W-1:0] lane_b_o,
  output logic              lane_oe_o
);
  logic [BYTE_W-1:0] hi_b, lo_b;

  assign hi_b = word_i[POS_W-1:BYTE_W];
  assign lo_b = word_i[BYTE_W-1:0];

  always_comb begin
    lane_oe_o = !oe_ni;
    lane_a_o  = '0;
    lane_b_o  = '0;
    if (!oe_ni) begin
      lane_a_o = byte_hi_i ? hi_b : lo_b;
      lane_b_o = lo_b;
    end
  end
endmodule

// File: rtl/pos_latch_if.sv
module pos_latch_if
  import pl_pkg::*;
#(
  parameter int BUSY_CYC    = 4,
  parameter int VALID_CYC   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              step_i,
  input  logic              inhibit_ni,
  input  logic [1:0]        res_sel_i,
  input  logic              oe_ni,
  input  logic              byte_hi_i,
  output logic [BYTE_W-1:0] lane_a_o,
  output logic [BYTE_W-1:0] lane_b_o,
  output logic              lane_oe_o,
  output logic              busy_o,
  output logic              valid_o
);
  logic             inh_s;   // synchronised, 1 = transfers allowed
  logic             inh_d;
  logic             inh_rise, inh_fall;
  logic             load;
  logic [POS_W-1:0] latch_q;

  pl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (inhibit_ni),
    .q_o   (inh_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) inh_d <= 1'b1;
    else         inh_d <= inh_s;

  assign inh_rise = inh_s && !inh_d;
  assign inh_fall = !inh_s && inh_d;
  assign load     = inh_s && (step_i || inh_rise);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   latch_q <= '0;
    else if (load) latch_q <= pos_i & res_mask(res_sel_i);

  pl_pulse #(.WIDTH(BUSY_CYC)) i_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(step_i || inh_rise),
    .busy_o (busy_o)
  );

  pl_valid_tmr #(.DELAY(VALID_CYC)) i_vtmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inh_act_i(!inh_s),
    .fall_i   (inh_fall),
    .valid_o  (valid_o)
  );

  pl_steer i_steer (
    .word_i   (latch_q),
    .byte_hi_i(byte_hi_i),
    .oe_ni    (oe_ni),
    .lane_a_o (lane_a_o),
    .lane_b_o (lane_b_o),
    .lane_oe_o(lane_oe_o)
  );
endmodule

// File: rtl/pl_chk.sv
module pl_chk
  import pl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_i,
  input logic [1:0]        res_sel_i,
  input logic              byte_hi_i,
  input logic [BYTE_W-1:0] lane_a_o,
  input logic [BYTE_W-1:0] lane_b_o,
  input logic              lane_oe_o,
  input logic              busy_o,
  input logic              valid_o,
  input logic              inh_s,
  input logic              inh_d,
  input logic [POS_W-1:0]  latch_q
);
  // R2
  step_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> busy_o);

  // R3
  inh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(latch_q) |-> $past(inh_s));

  // R4
  valid_inh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !inh_s);

  // R4
  valid_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $stable(latch_q));

  // R5
  refresh_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_s && !inh_d) |=> busy_o);

  // R6
  lane_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_oe_o |-> (lane_a_o == '0 && lane_b_o == '0));

  // R7
  lane_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_oe_o |-> lane_b_o == latch_q[BYTE_W-1:0]);

  // R8
  lane_a_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_oe_o && byte_hi_i) |-> lane_a_o == latch_q[POS_W-1:BYTE_W]);

  // R8
  lane_a_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_oe_o && !byte_hi_i) |-> lane_a_o == lane_b_o);

  // R9
  res_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(latch_q) |-> (latch_q & ~res_mask($past(res_sel_i))) == '0);
endmodule

bind pos_latch_if pl_chk i_pl_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .step_i   (step_i),
  .res_sel_i(res_sel_i),
  .byte_hi_i(byte_hi_i),
  .lane_a_o (lane_a_o),
  .lane_b_o (lane_b_o),
  .lane_oe_o(lane_oe_o),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .inh_s    (inh_s),
  .inh_d    (inh_d),
  .latch_q  (latch_q)
);

// File: tb/test_pos_latch_if.sv
module test_pos_latch_if;
  localparam int BUSY  = 4;
  localparam int VALID = 6;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] pos_i;
  logic        step_i, inhibit_ni, oe_ni, byte_hi_i;
  logic [1:0]  res_sel_i;
  logic [7:0]  lane_a_o, lane_b_o;
  logic        lane_oe_o, busy_o, valid_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int         due;
    logic [7:0] a;
    logic [7:0] b;
    logic       oe;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pos_latch_if #(.BUSY_CYC(BUSY), .VALID_CYC(VALID)) i_pos_latch_if (
    .clk_i(clk), .rst_ni(rst_ni), .pos_i(pos_i), .step_i(step_i),
    .inhibit_ni(inhibit_ni), .res_sel_i(res_sel_i), .oe_ni(oe_ni),
    .byte_hi_i(byte_hi_i), .lane_a_o(lane_a_o), .lane_b_o(lane_b_o),
    .lane_oe_o(lane_oe_o), .busy_o(busy_o), .valid_o(valid_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // driver side: queue expected lane state for the next sample
  task automatic exp_lanes(logic [7:0] a, logic [7:0] b, logic oe, string tag);
    exp_t e;
    e.due = cyc + 1; e.a = a; e.b = b; e.oe = oe; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  // monitor side
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      chk({e.tag, " lane_a"}, {24'd0, lane_a_o}, {24'd0, e.a});
      chk({e.tag, " lane_b"}, {24'd0, lane_b_o}, {24'd0, e.b});
      chk({e.tag, " lane_oe"}, {31'd0, lane_oe_o}, {31'd0, e.oe});
    end
  end

  task automatic do_step(logic [15:0] v);
    @(negedge clk);
    pos_i  = v;
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic busy_window(string tag);
    chk(tag, {31'd0, busy_o}, 32'd1);
    for (int i = 1; i < BUSY; i++) begin
      @(negedge clk);
      chk(tag, {31'd0, busy_o}, 32'd1);
    end
    @(negedge clk);
    chk({tag, " end"}, {31'd0, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; pos_i = '0; step_i = 1'b0; inhibit_ni = 1'b1;
    res_sel_i = 2'b11; oe_ni = 1'b1; byte_hi_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 valid", {31'd0, valid_o}, 32'd0);
    exp_lanes(8'h00, 8'h00, 1'b0, "R6 disabled after reset");
    oe_ni = 1'b0;
    exp_lanes(8'h00, 8'h00, 1'b1, "R1 latch cleared");

    // R2 load and busy width
    do_step(16'hA5C3);
    busy_window("R2 busy width");
    exp_lanes(8'hA5, 8'hC3, 1'b1, "R8 high byte R7");
    byte_hi_i = 1'b0;
    exp_lanes(8'hC3, 8'hC3, 1'b1, "R8 low duplicated R7");
    byte_hi_i = 1'b1;

    // R10 retrigger
    do_step(16'h0101);
    repeat (2) @(negedge clk);
    do_step(16'h0202);
    busy_window("R10 retrigger");

    // R9 resolution masking
    res_sel_i = 2'b00; do_step(16'hFFFF);
    exp_lanes(8'hFF, 8'hC0, 1'b1, "R9 10 bit");
    res_sel_i = 2'b01; do_step(16'hFFFF);
    exp_lanes(8'hFF, 8'hF0, 1'b1, "R9 12 bit");
    res_sel_i = 2'b10; do_step(16'hFFFF);
    exp_lanes(8'hFF, 8'hFC, 1'b1, "R9 14 bit");
    res_sel_i = 2'b11; do_step(16'hFFFF);
    exp_lanes(8'hFF, 8'hFF, 1'b1, "R9 16 bit");

    // R6 enable has no effect on latching
    oe_ni = 1'b1;
    exp_lanes(8'h00, 8'h00, 1'b0, "R6 high impedance");
    do_step(16'h1234);
    chk("R6 busy while disabled", {31'd0, busy_o}, 32'd1);
    exp_lanes(8'h00, 8'h00, 1'b0, "R6 still off");
    oe_ni = 1'b0;
    exp_lanes(8'h12, 8'h34, 1'b1, "R6 latch loaded while off");
    repeat (BUSY + 1) @(negedge clk);

    // R4 valid delay
    @(negedge clk);
    inhibit_ni = 1'b0;
    repeat (VALID + 2) @(negedge clk);
    chk("R4 valid early", {31'd0, valid_o}, 32'd0);
    @(negedge clk);
    chk("R4 valid on time", {31'd0, valid_o}, 32'd1);

    // R3 latch frozen, busy still runs
    do_step(16'h5555);
    chk("R3 busy during inhibit", {31'd0, busy_o}, 32'd1);
    exp_lanes(8'h12, 8'h34, 1'b1, "R3 latch held");
    chk("R4 valid held", {31'd0, valid_o}, 32'd1);
    repeat (BUSY + 2) @(negedge clk);
    chk("R3 busy ended", {31'd0, busy_o}, 32'd0);

    // R5 release refresh
    @(negedge clk);
    inhibit_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 no busy before refresh", {31'd0, busy_o}, 32'd0);
    chk("R4 valid drops", {31'd0, valid_o}, 32'd0);
    @(negedge clk);
    chk("R5 refresh busy", {31'd0, busy_o}, 32'd1);
    exp_lanes(8'h55, 8'h55, 1'b1, "R5 reload");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", sb_q.size(), 32'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule